// File: doc/BRIEF.md
# Decoupled Transcendental Push/Pop Pipeline

This block is the issue and drain control of a vector transcendental unit that does not write back like an ordinary ALU. A push hands over a source vector, a 6-bit source register number and a 5-bit selector. The selector names the function and the datatype together in one code. Each accepted push becomes an entry in an in-order result queue. Every entry carries its own countdown of the remaining latency. A later pop names only a 6-bit destination register, and it receives the oldest result once that result's latency has run out.

Two independent parameters shape the timing. The first is a push-to-pop latency, with separate values for F32 and BF16 work. The second is a reservation spacing that sets the minimum number of cycles between accepted pushes; a value of 2 gives half-rate issue. The reservation spacing never changes the latency. The arithmetic of the approximators is out of scope here. A tagged pass-through stands in for it: the result is the source vector XORed with a byte that identifies the function and the datatype.

Illegal traffic is flagged and then dropped. The push-rejected flag covers an undecodable selector, a full queue and a push inside the reservation window. The pop-error flag covers a pop against an empty queue and a pop against a head entry that is not yet ready. All outputs are registered and appear one cycle after the clock edge that accepted or refused the request.

Top module: `xcend_pipe`

## Requirements
- R1: F32 selector codes decode to function numbers as follows, with `res_bf16`=0: 0x0E→erf(0), 0x10→rsqrt(1), 0x11→pow2(2), 0x12→log2(3), 0x13→tanh(4), 0x14→shifted-sigmoid(5), 0x15→reciprocal(6), 0x17→sin(7), 0x18→cos(8).
- R2: BF16 selector codes decode with `res_bf16`=1 as follows: 0x0F→0, 0x0C→1, 0x19→2, 0x1A→3, 0x1B→4, 0x1C→5, 0x1D→6, 0x1E→7, 0x1F→8. The datatype is not a separate bit of the selector.
- R3: Selector 0x16 is a generic push. Its function number comes from `push_side_fn`, and it is treated as F32. A side value above 8 rejects the push.
- R4: Every other selector code (0x00–0x0B, 0x0D) rejects the push. `push_rej` is high in the cycle after the refused push, and no entry is added.
- R5: A pop is accepted only at a clock edge at least LAT_F32 (F32 entry) or LAT_BF16 (BF16 entry) edges after the edge that accepted the head entry's push. An earlier pop raises `pop_err` in the next cycle and leaves the queue unchanged.
- R6: Two accepted pushes are at least RESV edges apart. A push inside the window is rejected and does not restart the window. The spacing does not alter the latency, so N pushes at full spacing drain with the last pop at edge 2·(N−1)+LAT after the first push.
- R7: A push while the queue holds DEPTH entries is rejected with `push_rej`.
- R8: Results drain strictly in push order. In the cycle after an accepted pop, `res_valid`=1 and the outputs carry the following: `res_dst_reg` is the pop's register, and `res_src_reg`, `res_fn` and `res_bf16` come from the push. `res_data` is the push data XOR the byte {bf16, 3'b000, fn[3:0]} replicated across every byte.
- R9: A pop against an empty queue raises `pop_err` and returns nothing. This includes a pop in the same cycle as a push into an empty queue, because a push and its own pop are never accepted together.
- R10: After reset, `res_valid`, `push_rej` and `pop_err` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_sel | input | 5 | Function/datatype selector |
| push_side_fn | input | 4 | Function number used by the generic selector 0x16 |
| push_src_reg | input | 6 | Source register number |
| push_data | input | VEC_W | Source vector |
| pop_valid | input | 1 | Pop request |
| pop_dst_reg | input | 6 | Destination register number |
| res_valid | output | 1 | Result delivered for an accepted pop |
| res_dst_reg | output | 6 | Destination register of the pop |
| res_src_reg | output | 6 | Source register of the popped entry |
| res_fn | output | 4 | Function number of the popped entry |
| res_bf16 | output | 1 | Datatype of the popped entry (1 = BF16) |
| res_data | output | VEC_W | Result vector |
| push_rej | output | 1 | Previous cycle's push was refused |
| pop_err | output | 1 | Previous cycle's pop was refused |

## Verification
The hardest situation to reach is a refused push that falls inside the reservation window while the queue is also close to full. A bug there could restart the window or consume a slot. The stimulus gets there by pushing on back-to-back cycles: every other push is refused, and the queue fills with accepted pushes that land on alternating cycles. Pops are then placed one cycle before and exactly at each entry's ready edge, for both datatypes. A back-to-back pop train confirms that the half-rate spacing adds nothing to the latency.

// File: rtl/xcend_pkg.sv
package xcend_pkg;

    typedef enum logic [3:0] {
        FN_ERF   = 4'd0,
        FN_RSQRT = 4'd1,
        FN_POW2  = 4'd2,
        FN_LOG2  = 4'd3,
        FN_TANH  = 4'd4,
        FN_SSIG  = 4'd5,
        FN_RECIP = 4'd6,
        FN_SIN   = 4'd7,
        FN_COS   = 4'd8
    } xfn_e;

    localparam logic [4:0] SEL_GENERIC = 5'h16;
    localparam int unsigned FN_LAST    = 8;

    // Placeholder tag byte that marks a result with its function and datatype
    function automatic logic [7:0] tag_byte(input logic bf16, input xfn_e fn);
        return {bf16, 3'b000, fn};
    endfunction

endpackage

// File: rtl/xcend_sel_decode.sv
module xcend_sel_decode
    import xcend_pkg::*;
(
    input  logic [4:0] sel,
    input  logic [3:0] side_fn,
    output logic       dec_ok,
    output xfn_e       dec_fn,
    output logic       dec_bf16
);

    always_comb begin
        dec_ok   = 1'b1;
        dec_fn   = FN_ERF;
        dec_bf16 = 1'b0;
        unique case (sel)
            5'h0E: dec_fn = FN_ERF;
            5'h10: dec_fn = FN_RSQRT;
            5'h11: dec_fn = FN_POW2;
            5'h12: dec_fn = FN_LOG2;
            5'h13: dec_fn = FN_TANH;
            5'h14: dec_fn = FN_SSIG;
            5'h15: dec_fn = FN_RECIP;
            5'h17: dec_fn = FN_SIN;
            5'h18: dec_fn = FN_COS;
            5'h0F: begin dec_fn = FN_ERF;   dec_bf16 = 1'b1; end
            5'h0C: begin dec_fn = FN_RSQRT; dec_bf16 = 1'b1; end
            5'h19: begin dec_fn = FN_POW2;  dec_bf16 = 1'b1; end
            5'h1A: begin dec_fn = FN_LOG2;  dec_bf16 = 1'b1; end
            5'h1B: begin dec_fn = FN_TANH;  dec_bf16 = 1'b1; end
            5'h1C: begin dec_fn = FN_SSIG;  dec_bf16 = 1'b1; end
            5'h1D: begin dec_fn = FN_RECIP; dec_bf16 = 1'b1; end
            5'h1E: begin dec_fn = FN_SIN;   dec_bf16 = 1'b1; end
            5'h1F: begin dec_fn = FN_COS;   dec_bf16 = 1'b1; end
            SEL_GENERIC: begin
                // function arrives out of band; not a tenth function
                if (32'(side_fn) <= FN_LAST) dec_fn = xfn_e'(side_fn);
                else                         dec_ok = 1'b0;
            end
            default: dec_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/xcend_issue_gate.sv
module xcend_issue_gate #(
    parameter int unsigned RESV = 2,
    localparam int unsigned RW  = $clog2(RESV) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic open
);

    localparam logic [RW-1:0] RELOAD = RW'(RESV - 1);

    typedef struct packed {
        logic [RW-1:0] hold;
    } gstate_t;

    gstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire)                st_d.hold = RELOAD;
        else if (st_q.hold != 0) st_d.hold = st_q.hold - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open = (st_q.hold == '0);

endmodule

// File: rtl/xcend_result_fifo.sv
module xcend_result_fifo
    import xcend_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned VEC_W = 64,
    parameter int unsigned CNT_W = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  xfn_e             wr_fn,
    input  logic             wr_bf16,
    input  logic [5:0]       wr_src,
    input  logic [CNT_W-1:0] wr_wait,
    input  logic [VEC_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [OCC_W-1:0] occ,
    output logic             head_ready,
    output xfn_e             head_fn,
    output logic             head_bf16,
    output logic [5:0]       head_src,
    output logic [VEC_W-1:0] head_data
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [CNT_W-1:0] wait_n;
        xfn_e             fn;
        logic             bf16;
        logic [5:0]       src;
        logic [VEC_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0]  rp;
        logic [PTR_W-1:0]  wp;
        logic [OCC_W-1:0]  occ;
    } fstate_t;

    fstate_t st_d, st_q;
    logic [CNT_W-1:0] aged [DEPTH];

    // one latency down-counter per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        assign aged[i] = (st_q.slot[i].wait_n != '0) ? st_q.slot[i].wait_n - 1'b1 : '0;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) st_d.slot[i].wait_n = aged[i];
        if (wr_en) begin
            st_d.slot[st_q.wp].wait_n = wr_wait;
            st_d.slot[st_q.wp].fn     = wr_fn;
            st_d.slot[st_q.wp].bf16   = wr_bf16;
            st_d.slot[st_q.wp].src    = wr_src;
            st_d.slot[st_q.wp].data   = wr_data;
            st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (rd_en) st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + 1'b1;
        st_d.occ = st_q.occ + OCC_W'(wr_en) - OCC_W'(rd_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ        = st_q.occ;
    assign head_ready = (st_q.occ != '0) && (st_q.slot[st_q.rp].wait_n == '0);
    assign head_fn    = st_q.slot[st_q.rp].fn;
    assign head_bf16  = st_q.slot[st_q.rp].bf16;
    assign head_src   = st_q.slot[st_q.rp].src;
    assign head_data  = st_q.slot[st_q.rp].data;

endmodule

// File: rtl/xcend_pipe.sv
module xcend_pipe
    import xcend_pkg::*;
#(
    parameter int unsigned VEC_W    = 64,
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned LAT_F32  = 13,
    parameter int unsigned LAT_BF16 = 14,
    parameter int unsigned RESV     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [4:0]       push_sel,
    input  logic [3:0]       push_side_fn,
    input  logic [5:0]       push_src_reg,
    input  logic [VEC_W-1:0] push_data,
    input  logic             pop_valid,
    input  logic [5:0]       pop_dst_reg,
    output logic             res_valid,
    output logic [5:0]       res_dst_reg,
    output logic [5:0]       res_src_reg,
    output logic [3:0]       res_fn,
    output logic             res_bf16,
    output logic [VEC_W-1:0] res_data,
    output logic             push_rej,
    output logic             pop_err
);

    localparam int unsigned LAT_MAX = (LAT_F32 > LAT_BF16) ? LAT_F32 : LAT_BF16;
    localparam int unsigned CNT_W   = $clog2(LAT_MAX + 1);
    localparam int unsigned OCC_W   = $clog2(DEPTH + 1);
    localparam int unsigned NBYTES  = VEC_W / 8;
    localparam logic [CNT_W-1:0] WAIT_F32  = CNT_W'(LAT_F32 - 1);
    localparam logic [CNT_W-1:0] WAIT_BF16 = CNT_W'(LAT_BF16 - 1);

    typedef struct packed {
        logic             res_valid;
        logic [5:0]       res_dst;
        logic [5:0]       res_src;
        xfn_e             res_fn;
        logic             res_bf16;
        logic [VEC_W-1:0] res_data;
        logic             push_rej;
        logic             pop_err;
    } ostate_t;

    ostate_t out_d, out_q;

    logic             dec_ok, dec_bf16;
    xfn_e             dec_fn;
    logic             gate_open;
    logic             push_ok, pop_ok;
    logic [OCC_W-1:0] occ;
    logic             head_ready, head_bf16;
    xfn_e             head_fn;
    logic [5:0]       head_src;
    logic [VEC_W-1:0] head_data;
    logic [VEC_W-1:0] stand_in;
    logic [CNT_W-1:0] push_wait;

    xcend_sel_decode u_dec (
        .sel      (push_sel),
        .side_fn  (push_side_fn),
        .dec_ok   (dec_ok),
        .dec_fn   (dec_fn),
        .dec_bf16 (dec_bf16)
    );

    xcend_issue_gate #(.RESV(RESV)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (push_ok),
        .open  (gate_open)
    );

    // stand-in for the approximators: tagged pass-through
    always_comb begin
        stand_in = push_data ^ {NBYTES{tag_byte(dec_bf16, dec_fn)}};
        push_wait = dec_bf16 ? WAIT_BF16 : WAIT_F32;
    end

    assign push_ok = push_valid && dec_ok && gate_open && (occ != OCC_W'(DEPTH));
    assign pop_ok  = pop_valid && head_ready;

    xcend_result_fifo #(
        .DEPTH (DEPTH),
        .VEC_W (VEC_W),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (push_ok),
        .wr_fn      (dec_fn),
        .wr_bf16    (dec_bf16),
        .wr_src     (push_src_reg),
        .wr_wait    (push_wait),
        .wr_data    (stand_in),
        .rd_en      (pop_ok),
        .occ        (occ),
        .head_ready (head_ready),
        .head_fn    (head_fn),
        .head_bf16  (head_bf16),
        .head_src   (head_src),
        .head_data  (head_data)
    );

    always_comb begin
        out_d = out_q;
        out_d.res_valid = pop_ok;
        out_d.push_rej  = push_valid && !push_ok;
        out_d.pop_err   = pop_valid && !pop_ok;
        if (pop_ok) begin
            out_d.res_dst  = pop_dst_reg;
            out_d.res_src  = head_src;
            out_d.res_fn   = head_fn;
            out_d.res_bf16 = head_bf16;
            out_d.res_data = head_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_valid   = out_q.res_valid;
    assign res_dst_reg = out_q.res_dst;
    assign res_src_reg = out_q.res_src;
    assign res_fn      = out_q.res_fn;
    assign res_bf16    = out_q.res_bf16;
    assign res_data    = out_q.res_data;
    assign push_rej    = out_q.push_rej;
    assign pop_err     = out_q.pop_err;

endmodule

// File: rtl/xcend_pipe_checker.sv
module xcend_pipe_checker #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned RESV  = 2,
    parameter int unsigned OCC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             pop_valid,
    input logic             push_ok,
    input logic [OCC_W-1:0] occ,
    input logic             res_valid,
    input logic             push_rej,
    input logic             pop_err
);

    AST_POP_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && pop_err)); // R9

    AST_RESULT_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(pop_valid)); // R8

    AST_REJECT_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push_rej |-> $past(push_valid)); // R4

    AST_PUSH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (RESV > 1 && push_ok) |=> !push_ok); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH)); // R7

    AST_EMPTY_POP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && occ == '0) |=> pop_err); // R9

endmodule

bind xcend_pipe xcend_pipe_checker #(
    .DEPTH (DEPTH),
    .RESV  (RESV),
    .OCC_W (OCC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_valid  (pop_valid),
    .push_ok    (push_ok),
    .occ        (occ),
    .res_valid  (res_valid),
    .push_rej   (push_rej),
    .pop_err    (pop_err)
);

// File: tb/xcend_pipe_tb.sv
`timescale 1ns/1ps
module xcend_pipe_tb;

    localparam int VEC_W = 64;
    localparam int DEPTH = 4;
    localparam int LF    = 13;
    localparam int LB    = 14;
    localparam int RESV  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0, pop_valid = 1'b0;
    logic [4:0] push_sel = '0;
    logic [3:0] push_side_fn = '0;
    logic [5:0] push_src_reg = '0, pop_dst_reg = '0;
    logic [VEC_W-1:0] push_data = '0;
    logic res_valid, res_bf16, push_rej, pop_err;
    logic [5:0] res_dst_reg, res_src_reg;
    logic [3:0] res_fn;
    logic [VEC_W-1:0] res_data;

    always #10 clk = ~clk;

    xcend_pipe #(.VEC_W(VEC_W), .DEPTH(DEPTH), .LAT_F32(LF), .LAT_BF16(LB), .RESV(RESV)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_sel(push_sel),
        .push_side_fn(push_side_fn), .push_src_reg(push_src_reg), .push_data(push_data),
        .pop_valid(pop_valid), .pop_dst_reg(pop_dst_reg), .res_valid(res_valid),
        .res_dst_reg(res_dst_reg), .res_src_reg(res_src_reg), .res_fn(res_fn),
        .res_bf16(res_bf16), .res_data(res_data), .push_rej(push_rej), .pop_err(pop_err));

    typedef struct {
        int ready;
        logic [3:0] fn;
        bit bf;
        logic [5:0] src;
        logic [VEC_W-1:0] res;
        logic [5:0] dst;
    } item_t;

    item_t mq[$];   // model of queued entries
    item_t sbq[$];  // scoreboard of results due at the outputs
    int total = 0, bad = 0;
    int edge_n = 0, last_push = -100, last_pop_edge = -1;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // decode from the requirement tables R1, R2, R3
    function automatic bit bdec(input logic [4:0] s, input logic [3:0] side,
                                output logic [3:0] fn, output bit bf);
        bdec = 1; bf = 0; fn = 0;
        case (s)
            5'h0E: fn = 0;  5'h10: fn = 1;  5'h11: fn = 2;  5'h12: fn = 3;
            5'h13: fn = 4;  5'h14: fn = 5;  5'h15: fn = 6;  5'h17: fn = 7;
            5'h18: fn = 8;
            5'h0F: begin fn = 0; bf = 1; end
            5'h0C: begin fn = 1; bf = 1; end
            5'h19: begin fn = 2; bf = 1; end
            5'h1A: begin fn = 3; bf = 1; end
            5'h1B: begin fn = 4; bf = 1; end
            5'h1C: begin fn = 5; bf = 1; end
            5'h1D: begin fn = 6; bf = 1; end
            5'h1E: begin fn = 7; bf = 1; end
            5'h1F: begin fn = 8; bf = 1; end
            5'h16: begin if (side <= 8) fn = side; else bdec = 0; end
            default: bdec = 0;
        endcase
    endfunction

    // driver: one clock of stimulus, with the expected outcome predicted from the requirements
    task automatic step(input bit pv, input logic [4:0] sel, input logic [3:0] side,
                        input logic [5:0] src, input logic [VEC_W-1:0] d,
                        input bit qv, input logic [5:0] dst, input string req);
        bit ok_dec, bf, push_ok, pop_ok;
        logic [3:0] fn;
        item_t it;
        ok_dec = bdec(sel, side, fn, bf);
        pop_ok  = qv && mq.size() > 0 && edge_n >= mq[0].ready;
        push_ok = pv && ok_dec && mq.size() < DEPTH && (edge_n - last_push) >= RESV;
        if (pop_ok) begin
            it = mq.pop_front();
            it.dst = dst;
            sbq.push_back(it);
            last_pop_edge = edge_n;
        end
        if (push_ok) begin
            it.ready = edge_n + (bf ? LB : LF);
            it.fn = fn; it.bf = bf; it.src = src; it.dst = 0;
            it.res = d ^ {(VEC_W/8){bf, 3'b000, fn}};
            mq.push_back(it);
            last_push = edge_n;
        end
        push_valid = pv; push_sel = sel; push_side_fn = side; push_src_reg = src;
        push_data = d; pop_valid = qv; pop_dst_reg = dst;
        @(negedge clk);
        edge_n++;
        chk(push_rej === (pv && !push_ok), req, 64'(push_rej), 64'(pv && !push_ok));
        chk(pop_err === (qv && !pop_ok), req, 64'(pop_err), 64'(qv && !pop_ok));
        chk(res_valid === pop_ok, req, 64'(res_valid), 64'(pop_ok));
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic push(input logic [4:0] sel, input logic [3:0] side, input logic [5:0] src,
                        input logic [VEC_W-1:0] d, input string req);
        step(1, sel, side, src, d, 0, 0, req);
    endtask

    task automatic pop(input logic [5:0] dst, input string req);
        step(0, 0, 0, 0, 0, 1, dst, req);
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while (mq.size() > 0 && guard < 40) begin
            pop(6'(guard + 7), req);
            guard++;
        end
    endtask

    // monitor: compare delivered results against the scoreboard (R8 order and payload)
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            item_t e;
            if (sbq.size() == 0) begin
                chk(0, "R8 unexpected result", 64'(res_fn), 0);
            end else begin
                e = sbq.pop_front();
                chk(res_data === e.res, "R8 data", res_data, e.res);
                chk(res_fn === e.fn, "R1/R2 fn", 64'(res_fn), 64'(e.fn));
                chk(res_bf16 === e.bf, "R2 dtype", 64'(res_bf16), 64'(e.bf));
                chk(res_src_reg === e.src, "R8 src", 64'(res_src_reg), 64'(e.src));
                chk(res_dst_reg === e.dst, "R8 dst", 64'(res_dst_reg), 64'(e.dst));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    logic [4:0] codes [18] = '{5'h0E, 5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15, 5'h17, 5'h18,
                               5'h0F, 5'h0C, 5'h19, 5'h1A, 5'h1B, 5'h1C, 5'h1D, 5'h1E, 5'h1F};

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk(res_valid === 0, "R10", 64'(res_valid), 0);
        chk(push_rej === 0, "R10", 64'(push_rej), 0);
        chk(pop_err === 0, "R10", 64'(pop_err), 0);

        // R9 pop on empty queue, and pop together with a push into an empty queue
        pop(6'd1, "R9");
        step(1, 5'h13, 0, 6'd2, 64'h1111, 1, 6'd3, "R9");
        drain("R9");

        // R5 F32 latency: early pop refused, pop at the ready edge accepted
        push(5'h13, 0, 6'd4, 64'hA5A5_0000_FFFF_1234, "R5");
        idle(LF - 2, "R5");
        pop(6'd5, "R5");  // edge push+LF-1 -> error
        pop(6'd5, "R5");  // edge push+LF -> result
        // R5 BF16 latency
        push(5'h1B, 0, 6'd6, 64'h0123_4567_89AB_CDEF, "R5");
        idle(LB - 2, "R5");
        pop(6'd7, "R5");
        pop(6'd7, "R5");

        // R1 R2 every mapped selector
        foreach (codes[i]) begin
            push(codes[i], 0, 6'(i), {32'(i), 32'hDEAD_0000 + 32'(i)}, "R1");
            idle(LB - 1, "R2");
            pop(6'(40 + i), "R2");
        end

        // R3 generic selector with side function, then out-of-range side value
        push(5'h16, 4'd3, 6'd9, 64'h5555, "R3");
        idle(1, "R3");
        push(5'h16, 4'd9, 6'd9, 64'h6666, "R3");
        push(5'h16, 4'd8, 6'd10, 64'h7777, "R3");
        drain("R3");

        // R4 undecodable codes
        push(5'h0D, 0, 0, 64'h1, "R4");
        push(5'h00, 0, 0, 64'h2, "R4");
        push(5'h0B, 0, 0, 64'h3, "R4");
        pop(6'd1, "R4");  // queue must still be empty

        // R6 back-to-back pushes: every other one refused, window not restarted
        // R7 the queue fills and further pushes are refused
        idle(2, "R6");
        for (int i = 0; i < 10; i++) push(i[0] ? 5'h1C : 5'h11, 0, 6'(20 + i), 64'(i * 3 + 1), "R7");
        drain("R7");

        // R6 throughput: 4 pushes at full spacing, last pop at p0 + 2*3 + LF
        idle(2, "R6");
        p0 = edge_n;
        for (int i = 0; i < 4; i++) begin
            push(5'h15, 0, 6'(30 + i), 64'(100 + i), "R6");
            if (i < 3) idle(1, "R6");
        end
        while (mq.size() > 0) pop(6'd50, "R8");
        chk(last_pop_edge == p0 + RESV * 3 + LF, "R6 spacing vs latency",
            64'(last_pop_edge - p0), 64'(RESV * 3 + LF));

        idle(2, "R8");
        chk(sbq.size() == 0, "R8 all results delivered", 64'(sbq.size()), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule